// File: doc/BRIEF.md
# Chained Descriptor Data Mover

This block moves one data unit each time a peripheral raises an event flag. Each event has an enable bit held inside the block. When an enabled event is pending and the engine is idle, the engine reads a descriptor pointer from a vector table at `VEC_BASE + 2*event`. It then reads the descriptor at that address: a mode word, a source address, a destination address, a transfer count and a spare word. The engine copies one byte or one 16-bit word from source to destination and writes back the updated source, destination and count. If the descriptor asks for chaining, the engine goes on to the next descriptor, which sits 10 bytes after the current one.

The last descriptor of a chain decides how the event ends. If its count has not finished, the engine pulses the event's flag-clear line so the peripheral drops its request. If a normal-mode count has reached zero, the engine leaves the flag alone, clears the event's enable and pulses the CPU interrupt, naming the event. Repeat mode never finishes. Its working count reloads and its repeat-area address returns to the start, so long runs can be built by chaining a second descriptor only when the count wraps.

The memory port is byte addressed with 16 bits of data. Words are stored high byte first at even addresses. Read data is valid in the cycle after the request.

Top module: `chain_xfer_engine`

## Requirements
- R1: With the engine idle, an event whose request and enable are both high is accepted; the lowest-numbered such event wins. The engine reads a word at `VEC_BASE + 2*event` and uses it as the descriptor address.
- R2: The descriptor is five words at byte offsets +0 mode, +2 source address, +4 destination address, +6 count, +8 spare. All five are read. Only source, destination and count are written back, and the spare word is never written.
- R3: Mode-word bits [9:8] select the unit: 00 is a byte and 01 is a 16-bit word. The address step is 1 for a byte and 2 for a word. A byte read uses data bits [7:0], and a byte write stores the low data byte.
- R4: Mode-word bits [15:14] (source) and [13:12] (destination) select the address behaviour. 00 holds the address fixed; 10 steps it by the unit size after each transfer (11 acts as 10, 01 as 00).
- R5: Mode-word bits [11:10] equal to 00 select normal mode. In normal mode the 16-bit count drops by one per transfer.
- R6: Mode-word bits [11:10] equal to 01 select repeat mode. In repeat mode the count's low byte is the working count and its high byte the reload value. When the low byte reaches zero it is reloaded from the high byte. The repeat-area address (source if mode bit 5 is 1, otherwise destination) then drops back by reload × step; a reload of 0 means 256.
- R7: Mode bit 7 enables chaining to the descriptor 10 bytes further on. Mode bit 6 at 0 chains after every transfer; at 1 it chains only when this descriptor's count reached zero.
- R8: If the last descriptor processed did not end a normal-mode count, `flag_clr` pulses for one cycle on that event's bit only. The interrupt stays low and the enable stays set.
- R9: If the last descriptor is in normal mode and its count reached zero, `flag_clr` stays low and the event's enable is cleared. `irq` pulses for one cycle, and `irq_evt` names the event.
- R10: `busy` is high from acceptance until the final write-back is complete. Events raised meanwhile stay pending and are served afterwards.
- R11: After reset, `busy`, `irq`, `flag_clr` and all enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_req | input | NUM_EVT | Peripheral event flags (level) |
| en_set | input | NUM_EVT | One-cycle pulses setting event enables |
| evt_en | output | NUM_EVT | Current event enables |
| flag_clr | output | NUM_EVT | One-cycle pulse telling a peripheral to clear its flag |
| irq | output | 1 | One-cycle CPU interrupt pulse at end of count |
| irq_evt | output | $clog2(NUM_EVT) | Event that raised the last interrupt |
| busy | output | 1 | Engine is processing an event |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_word | output | 1 | Access size: 1 word, 0 byte |
| mem_addr | output | ADDR_W | Byte address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid the cycle after a read request |

## Verification
The hardest case is the count-gated chain. The second descriptor must run only on the event where the first descriptor's repeat count wraps, and the two descriptors must finish with different outcomes. The stimulus places a repeat descriptor with a reload of 2 ahead of a normal descriptor and fires the same event twice. After the first event the bench checks that the second descriptor's count and target are untouched; after the second it checks that both have moved. Pending-event ordering is reached by raising two enabled flags in the same cycle. The bench samples during the single idle cycle between them, so it can check that only the lower event has been served.

// File: rtl/cxe_pkg.sv
package cxe_pkg;
  localparam int DESC_WORDS = 5;
  localparam int DESC_BYTES = 2 * DESC_WORDS;

  localparam logic [1:0] SZ_BYTE   = 2'b00;
  localparam logic [1:0] SZ_WORD   = 2'b01;
  localparam logic [1:0] XM_NORMAL = 2'b00;
  localparam logic [1:0] XM_REPEAT = 2'b01;

  // Mode word bits [15:5]; bits [4:0] are ignored.
  typedef struct packed {
    logic [1:0] src_mode;
    logic [1:0] dst_mode;
    logic [1:0] xfer_mode;
    logic [1:0] unit_size;
    logic       chain_en;
    logic       chain_zero;
    logic       rpt_src;
  } cxe_mode_t;

  typedef enum logic [3:0] {
    ST_IDLE, ST_VEC_RD, ST_VEC_CAP, ST_DSC_RD, ST_DSC_CAP,
    ST_SRC_RD, ST_SRC_CAP, ST_DST_WR, ST_WB, ST_FIN
  } cxe_state_t;
endpackage

// File: rtl/cxe_evt_arb.sv
module cxe_evt_arb #(
  parameter int NEV = 4,
  localparam int IW = $clog2(NEV)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NEV-1:0] evt_req,
  input  logic [NEV-1:0] en_set,
  input  logic [NEV-1:0] en_clr,
  input  logic           idle,
  output logic [NEV-1:0] en,
  output logic           grant_vld,
  output logic [IW-1:0]  grant_idx
);
  logic [NEV-1:0] live;
  logic [IW-1:0]  pick [NEV+1];

  assign live = evt_req & en;

  // clear has priority over set
  always_ff @(posedge clk) begin
    if (rst) en <= '0;
    else     en <= (en | en_set) & ~en_clr;
  end

  // fixed priority chain: lowest live index wins
  assign pick[NEV] = '0;
  generate
    for (genvar g = NEV - 1; g >= 0; g--) begin : g_pick
      assign pick[g] = live[g] ? IW'(g) : pick[g+1];
    end
  endgenerate

  assign grant_idx = pick[0];
  assign grant_vld = idle & (|live);

  AST_CLR_WINS: assert property (@(posedge clk) disable iff (rst)
    (|en_clr) |=> ((en & $past(en_clr)) == '0)); // R9

  AST_GRANT_LIVE: assert property (@(posedge clk) disable iff (rst)
    grant_vld |-> (evt_req[grant_idx] && en[grant_idx])); // R1
endmodule

// File: rtl/cxe_step.sv
module cxe_step #(
  parameter int AW = 16
) (
  input  logic [1:0]    src_mode,
  input  logic [1:0]    dst_mode,
  input  logic [1:0]    xfer_mode,
  input  logic [1:0]    unit_size,
  input  logic          rpt_src,
  input  logic [AW-1:0] sar,
  input  logic [AW-1:0] dar,
  input  logic [15:0]   cra,
  output logic [AW-1:0] sar_n,
  output logic [AW-1:0] dar_n,
  output logic [15:0]   cra_n,
  output logic          cnt_zero
);
  logic          word, src_inc, dst_inc, rpt;
  logic [AW-1:0] step, span;
  logic [8:0]    reload;
  logic [7:0]    lo_n;

  always_comb begin
    word    = (unit_size == SZ_WORD_L);
    src_inc = (src_mode >= 2'b10);
    dst_inc = (dst_mode >= 2'b10);
    rpt     = (xfer_mode == XM_REPEAT_L);
    step    = word ? AW'(2) : AW'(1);
    reload  = (cra[15:8] == 8'd0) ? 9'd256 : {1'b0, cra[15:8]};
    span    = word ? AW'({reload, 1'b0}) : AW'(reload);
    sar_n   = src_inc ? sar + step : sar;
    dar_n   = dst_inc ? dar + step : dar;
    lo_n    = cra[7:0] - 8'd1;
    if (rpt) begin
      cnt_zero = (lo_n == 8'd0);
      cra_n    = cnt_zero ? {cra[15:8], cra[15:8]} : {cra[15:8], lo_n};
      if (cnt_zero && rpt_src && src_inc)   sar_n = sar_n - span;
      if (cnt_zero && !rpt_src && dst_inc)  dar_n = dar_n - span;
    end else begin
      cra_n    = cra - 16'd1;
      cnt_zero = (cra_n == 16'd0);
    end
  end

  localparam logic [1:0] SZ_WORD_L   = 2'b01;
  localparam logic [1:0] XM_REPEAT_L = 2'b01;
endmodule

// File: rtl/cxe_ctrl.sv
module cxe_ctrl import cxe_pkg::*; #(
  parameter int NEV = 4,
  parameter int AW = 16,
  parameter logic [AW-1:0] VEC_BASE = '0,
  localparam int IW = $clog2(NEV)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           grant_vld,
  input  logic [IW-1:0]  grant_idx,
  output logic           idle,
  output logic           busy,
  output logic           mem_req,
  output logic           mem_we,
  output logic           mem_word,
  output logic [AW-1:0]  mem_addr,
  output logic [15:0]    mem_wdata,
  input  logic [15:0]    mem_rdata,
  output logic [NEV-1:0] flag_clr,
  output logic [NEV-1:0] en_clr,
  output logic           irq,
  output logic [IW-1:0]  irq_evt
);
  cxe_state_t    st;
  cxe_mode_t     mode_q;
  logic [IW-1:0] evt_q;
  logic [AW-1:0] base_q, sar_q, dar_q, sar_n, dar_n;
  logic [15:0]   cra_q, cra_n, data_q;
  logic [2:0]    idx_q;
  logic          zero_q, zero_n, unit_word;

  assign idle      = (st == ST_IDLE);
  assign busy      = !idle;
  assign unit_word = (mode_q.unit_size == SZ_WORD);

  cxe_step #(.AW(AW)) step_i (
    .src_mode (mode_q.src_mode),
    .dst_mode (mode_q.dst_mode),
    .xfer_mode(mode_q.xfer_mode),
    .unit_size(mode_q.unit_size),
    .rpt_src  (mode_q.rpt_src),
    .sar      (sar_q),
    .dar      (dar_q),
    .cra      (cra_q),
    .sar_n    (sar_n),
    .dar_n    (dar_n),
    .cra_n    (cra_n),
    .cnt_zero (zero_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      evt_q    <= '0;
      base_q   <= '0;
      sar_q    <= '0;
      dar_q    <= '0;
      cra_q    <= '0;
      data_q   <= '0;
      mode_q   <= '0;
      idx_q    <= '0;
      zero_q   <= 1'b0;
      flag_clr <= '0;
      en_clr   <= '0;
      irq      <= 1'b0;
      irq_evt  <= '0;
    end else begin
      flag_clr <= '0;
      en_clr   <= '0;
      irq      <= 1'b0;
      case (st)
        ST_IDLE:    if (grant_vld) begin evt_q <= grant_idx; st <= ST_VEC_RD; end
        ST_VEC_RD:  st <= ST_VEC_CAP;
        ST_VEC_CAP: begin base_q <= mem_rdata[AW-1:0]; idx_q <= '0; st <= ST_DSC_RD; end
        ST_DSC_RD:  st <= ST_DSC_CAP;
        ST_DSC_CAP: begin
          case (idx_q)
            3'd0:    mode_q <= mem_rdata[15:5];
            3'd1:    sar_q  <= mem_rdata[AW-1:0];
            3'd2:    dar_q  <= mem_rdata[AW-1:0];
            3'd3:    cra_q  <= mem_rdata;
            default: ;
          endcase
          if (idx_q == 3'(DESC_WORDS - 1)) st <= ST_SRC_RD;
          else begin idx_q <= idx_q + 3'd1; st <= ST_DSC_RD; end
        end
        ST_SRC_RD:  st <= ST_SRC_CAP;
        ST_SRC_CAP: begin data_q <= mem_rdata; st <= ST_DST_WR; end
        ST_DST_WR: begin
          sar_q  <= sar_n;
          dar_q  <= dar_n;
          cra_q  <= cra_n;
          zero_q <= zero_n;
          idx_q  <= '0;
          st     <= ST_WB;
        end
        ST_WB: begin
          if (idx_q == 3'd2) begin
            if (mode_q.chain_en && (!mode_q.chain_zero || zero_q)) begin
              base_q <= base_q + AW'(DESC_BYTES);
              idx_q  <= '0;
              st     <= ST_DSC_RD;
            end else begin
              st <= ST_FIN;
              if (mode_q.xfer_mode != XM_REPEAT && zero_q) begin
                irq     <= 1'b1;
                irq_evt <= evt_q;
                en_clr  <= NEV'(1) << evt_q;
              end else begin
                flag_clr <= NEV'(1) << evt_q;
              end
            end
          end else begin
            idx_q <= idx_q + 3'd1;
          end
        end
        ST_FIN:  st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_word  = 1'b1;
    mem_addr  = '0;
    mem_wdata = '0;
    case (st)
      ST_VEC_RD: begin
        mem_req  = 1'b1;
        mem_addr = VEC_BASE + (AW'(evt_q) << 1);
      end
      ST_DSC_RD: begin
        mem_req  = 1'b1;
        mem_addr = base_q + (AW'(idx_q) << 1);
      end
      ST_SRC_RD: begin
        mem_req  = 1'b1;
        mem_word = unit_word;
        mem_addr = sar_q;
      end
      ST_DST_WR: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_word  = unit_word;
        mem_addr  = dar_q;
        mem_wdata = data_q;
      end
      ST_WB: begin
        mem_req  = 1'b1;
        mem_we   = 1'b1;
        mem_addr = base_q + AW'(2) + (AW'(idx_q) << 1);
        case (idx_q)
          3'd0:    mem_wdata = 16'(sar_q);
          3'd1:    mem_wdata = 16'(dar_q);
          default: mem_wdata = cra_q;
        endcase
      end
      default: ;
    endcase
  end

  AST_BUSY_FROM_GRANT: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(grant_vld)); // R10

  AST_FIXED_SRC_HOLD: assert property (@(posedge clk) disable iff (rst)
    (st == ST_DST_WR && mode_q.src_mode < 2'b10) |=> (sar_q == $past(sar_q))); // R4

  AST_WORD_STEP: assert property (@(posedge clk) disable iff (rst)
    (st == ST_DST_WR && mode_q.src_mode >= 2'b10 && unit_word &&
     mode_q.xfer_mode == XM_NORMAL) |=> (sar_q == $past(sar_q) + AW'(2))); // R3

  AST_RPT_NO_ZERO_WB: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WB && idx_q == 3'd2 && mode_q.xfer_mode == XM_REPEAT &&
     mem_wdata[15:8] != 8'd0) |-> (mem_wdata[7:0] != 8'd0)); // R6

  AST_NORMAL_DEC: assert property (@(posedge clk) disable iff (rst)
    (st == ST_DST_WR && mode_q.xfer_mode == XM_NORMAL) |=>
    (cra_q == $past(cra_q) - 16'd1)); // R5
endmodule

// File: rtl/chain_xfer_engine.sv
module chain_xfer_engine import cxe_pkg::*; #(
  parameter int NUM_EVT = 4,
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] VEC_BASE = '0,
  localparam int EW = $clog2(NUM_EVT)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_EVT-1:0] evt_req,
  input  logic [NUM_EVT-1:0] en_set,
  output logic [NUM_EVT-1:0] evt_en,
  output logic [NUM_EVT-1:0] flag_clr,
  output logic               irq,
  output logic [EW-1:0]      irq_evt,
  output logic               busy,
  output logic               mem_req,
  output logic               mem_we,
  output logic               mem_word,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [15:0]        mem_wdata,
  input  logic [15:0]        mem_rdata
);
  logic               idle, grant_vld;
  logic [EW-1:0]      grant_idx;
  logic [NUM_EVT-1:0] en_clr;

  cxe_evt_arb #(.NEV(NUM_EVT)) arb_i (
    .clk      (clk),
    .rst      (rst),
    .evt_req  (evt_req),
    .en_set   (en_set),
    .en_clr   (en_clr),
    .idle     (idle),
    .en       (evt_en),
    .grant_vld(grant_vld),
    .grant_idx(grant_idx)
  );

  cxe_ctrl #(.NEV(NUM_EVT), .AW(ADDR_W), .VEC_BASE(VEC_BASE)) ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .grant_vld(grant_vld),
    .grant_idx(grant_idx),
    .idle     (idle),
    .busy     (busy),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_word (mem_word),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata),
    .flag_clr (flag_clr),
    .en_clr   (en_clr),
    .irq      (irq),
    .irq_evt  (irq_evt)
  );

  AST_CLR_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(flag_clr)); // R8

  AST_IRQ_NO_CLR: assert property (@(posedge clk) disable iff (rst)
    irq |-> (flag_clr == '0)); // R9

  AST_IRQ_DISABLES: assert property (@(posedge clk) disable iff (rst)
    irq |=> !evt_en[irq_evt]); // R9

  AST_CLR_KEEPS_EN: assert property (@(posedge clk) disable iff (rst)
    (|flag_clr) |-> ((flag_clr & evt_en) == flag_clr)); // R8
endmodule

// File: tb/chain_xfer_engine_tb_top.sv
module chain_xfer_engine_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NEV = 4;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [NEV-1:0] req = '0, req_set = '0, req_drop = '0, en_set = '0;
  logic [NEV-1:0] evt_en, flag_clr;
  logic           irq, busy, mem_req, mem_we, mem_word;
  logic [1:0]     irq_evt;
  logic [15:0]    mem_addr, mem_wdata, mem_rdata = '0;
  logic           bd_we = 1'b0;
  logic [8:0]     bd_addr = '0;
  logic [15:0]    bd_data = '0;
  logic [7:0]     mem [0:511] = '{default: 8'h00};
  int             clr_cnt [NEV] = '{default: 0};
  int             irq_cnt = 0;
  logic [1:0]     irq_cap = '0;
  int             n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  chain_xfer_engine #(.NUM_EVT(NEV), .ADDR_W(16), .VEC_BASE(16'h0000)) dut_i (
    .clk(clk), .rst(rst), .evt_req(req), .en_set(en_set), .evt_en(evt_en),
    .flag_clr(flag_clr), .irq(irq), .irq_evt(irq_evt), .busy(busy),
    .mem_req(mem_req), .mem_we(mem_we), .mem_word(mem_word), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // memory model, peripheral flag model, event counters
  always @(posedge clk) begin
    if (bd_we) begin
      mem[bd_addr] <= bd_data[15:8];
      mem[9'(bd_addr + 9'd1)] <= bd_data[7:0];
    end
    if (mem_req) begin
      if (mem_we) begin
        if (mem_word) begin
          mem[mem_addr[8:0]] <= mem_wdata[15:8];
          mem[9'(mem_addr[8:0] + 9'd1)] <= mem_wdata[7:0];
        end else begin
          mem[mem_addr[8:0]] <= mem_wdata[7:0];
        end
      end else begin
        mem_rdata <= mem_word ? {mem[mem_addr[8:0]], mem[9'(mem_addr[8:0] + 9'd1)]}
                              : {8'h00, mem[mem_addr[8:0]]};
      end
    end
    req <= (req | req_set) & ~flag_clr & ~req_drop;
    for (int i = 0; i < NEV; i++) if (flag_clr[i]) clr_cnt[i] <= clr_cnt[i] + 1;
    if (irq) begin irq_cnt <= irq_cnt + 1; irq_cap <= irq_evt; end
  end

  function automatic logic [15:0] peek16(input int a);
    return {mem[a], mem[a+1]};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic poke16(input int a, input logic [15:0] d);
    @(negedge clk); bd_we = 1'b1; bd_addr = 9'(a); bd_data = d;
    @(negedge clk); bd_we = 1'b0;
  endtask

  task automatic enable(input int e);
    @(negedge clk); en_set = NEV'(1) << e;
    @(negedge clk); en_set = '0;
  endtask

  task automatic drop(input int e);
    @(negedge clk); req_drop = NEV'(1) << e;
    @(negedge clk); req_drop = '0;
  endtask

  task automatic wait_done();
    int n;
    n = 0;
    while (!busy && n < 20) begin @(negedge clk); n++; end
    n = 0;
    while (busy && n < 400) begin @(negedge clk); n++; end
    repeat (2) @(negedge clk);
  endtask

  task automatic fire(input int e);
    @(negedge clk); req_set = NEV'(1) << e;
    @(negedge clk); req_set = '0;
    wait_done();
  endtask

  task automatic put_desc(input int a, input logic [15:0] md, input logic [15:0] s,
                          input logic [15:0] d, input logic [15:0] c);
    poke16(a, md); poke16(a + 2, s); poke16(a + 4, d); poke16(a + 6, c);
    poke16(a + 8, 16'hBEEF);
  endtask

  task automatic t_reset();
    chk("R11 busy", busy, 0);
    chk("R11 irq", irq, 0);
    chk("R11 flag_clr", flag_clr, 0);
    chk("R11 enables", evt_en, 0);
  endtask

  // normal word transfer, src increments, dst fixed, count 3
  task automatic t_normal();
    poke16(16'h000, 16'h0040);
    put_desc(16'h040, 16'h8100, 16'h0100, 16'h0180, 16'd3);
    poke16(16'h100, 16'h1111); poke16(16'h102, 16'h2222); poke16(16'h104, 16'h3333);
    enable(0);
    fire(0);
    chk("R1 first word moved", peek16(16'h180), 16'h1111);
    chk("R3 word step on SAR", peek16(16'h042), 16'h0102);
    chk("R4 fixed DAR", peek16(16'h044), 16'h0180);
    chk("R5 count dec", peek16(16'h046), 16'd2);
    chk("R2 spare untouched", peek16(16'h048), 16'hBEEF);
    chk("R8 flag cleared once", clr_cnt[0], 1);
    chk("R8 enable kept", evt_en[0], 1);
    fire(0);
    fire(0);
    chk("R5 third word", peek16(16'h180), 16'h3333);
    chk("R5 count zero", peek16(16'h046), 16'd0);
    chk("R9 no clear on end", clr_cnt[0], 2);
    chk("R9 flag kept", req[0], 1);
    chk("R9 irq once", irq_cnt, 1);
    chk("R9 irq event", irq_cap, 0);
    chk("R9 enable cleared", evt_en[0], 0);
    drop(0);
  endtask

  // byte transfer, src fixed, dst increments
  task automatic t_byte();
    poke16(16'h002, 16'h0050);
    put_desc(16'h050, 16'h2000, 16'h0110, 16'h0190, 16'd5);
    poke16(16'h110, 16'hA500);
    enable(1);
    fire(1);
    poke16(16'h110, 16'h3C00);
    fire(1);
    chk("R3 byte 0", mem[16'h190], 8'hA5);
    chk("R3 byte 1", mem[16'h191], 8'h3C);
    chk("R3 byte neighbour", mem[16'h192], 8'h00);
    chk("R3 byte step DAR", peek16(16'h054), 16'h0192);
    chk("R4 fixed SAR", peek16(16'h052), 16'h0110);
    chk("R5 byte count", peek16(16'h056), 16'd3);
  endtask

  // repeat mode, destination is repeat area, reload 2
  task automatic t_repeat();
    poke16(16'h004, 16'h0060);
    put_desc(16'h060, 16'hA500, 16'h0120, 16'h01A0, 16'h0202);
    poke16(16'h120, 16'hAAA0); poke16(16'h122, 16'hAAA1); poke16(16'h124, 16'hAAA2);
    enable(2);
    fire(2);
    chk("R6 working count", peek16(16'h066), 16'h0201);
    fire(2);
    chk("R6 second word", peek16(16'h1A2), 16'hAAA1);
    chk("R6 dst back to start", peek16(16'h064), 16'h01A0);
    chk("R6 count reloaded", peek16(16'h066), 16'h0202);
    chk("R6 src keeps going", peek16(16'h062), 16'h0124);
    chk("R6 no irq", irq_cnt, 1);
    chk("R6 flag cleared", clr_cnt[2], 2);
    fire(2);
    chk("R6 wrap overwrite", peek16(16'h1A0), 16'hAAA2);
  endtask

  // unconditional chain: repeat src-area descriptor then normal one
  task automatic t_chain();
    poke16(16'h006, 16'h0070);
    put_desc(16'h070, 16'h85A0, 16'h0130, 16'h01B0, 16'h0202);
    put_desc(16'h07A, 16'h8100, 16'h0140, 16'h01B2, 16'd2);
    poke16(16'h130, 16'h0101); poke16(16'h132, 16'h0202);
    poke16(16'h140, 16'h0F01); poke16(16'h142, 16'h0F02);
    enable(3);
    fire(3);
    chk("R7 first desc ran", peek16(16'h1B0), 16'h0101);
    chk("R7 chained desc ran", peek16(16'h1B2), 16'h0F01);
    chk("R7 chained count", peek16(16'h080), 16'd1);
    chk("R8 chain clears", clr_cnt[3], 1);
    fire(3);
    chk("R6 src area back", peek16(16'h072), 16'h0130);
    chk("R7 second chained", peek16(16'h1B2), 16'h0F02);
    chk("R9 chain end irq", irq_cnt, 2);
    chk("R9 chain irq event", irq_cap, 3);
    chk("R9 chain enable off", evt_en[3], 0);
    chk("R9 chain no clear", clr_cnt[3], 1);
    drop(3);
  endtask

  // chain only when count reaches zero
  task automatic t_chain_zero();
    poke16(16'h000, 16'h0090);
    put_desc(16'h090, 16'h85E0, 16'h0150, 16'h01C0, 16'h0202);
    put_desc(16'h09A, 16'h8100, 16'h0160, 16'h01C2, 16'd5);
    poke16(16'h150, 16'h1234); poke16(16'h152, 16'h5678); poke16(16'h160, 16'h9ABC);
    enable(0);
    fire(0);
    chk("R7 no chain yet data", peek16(16'h1C2), 16'h0000);
    chk("R7 no chain yet count", peek16(16'h0A0), 16'd5);
    fire(0);
    chk("R7 first desc second", peek16(16'h1C0), 16'h5678);
    chk("R7 chain on zero data", peek16(16'h1C2), 16'h9ABC);
    chk("R7 chain on zero count", peek16(16'h0A0), 16'd4);
    chk("R8 clear after chain", clr_cnt[0], 4);
  endtask

  // two events at once: lowest first, other held pending
  task automatic t_pending();
    int n;
    @(negedge clk); req_set = 4'b0110;
    @(negedge clk); req_set = '0;
    n = 0;
    while (!busy && n < 20) begin @(negedge clk); n++; end
    chk("R10 busy raised", busy, 1);
    n = 0;
    while (busy && n < 400) begin @(negedge clk); n++; end
    chk("R1 lower event served", clr_cnt[1], 3);
    chk("R10 higher event held", clr_cnt[2], 3);
    chk("R10 still pending", req[2], 1);
    wait_done();
    chk("R10 pending served", clr_cnt[2], 4);
    chk("R5 lower count", peek16(16'h056), 16'd2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_normal();
    t_byte();
    t_repeat();
    t_chain();
    t_chain_zero();
    t_pending();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule